// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase-shifted square waves of an incremental rotary or linear encoder into a signed-direction position count. Both channels are first brought into the clock domain through a two-stage synchronizer. An edge detector then decides, on every transition, whether the edge is counted and in which direction. The direction comes from the level of the opposite channel after the edge.

A 2-bit mode input picks the resolution. Mode 1 counts edges of channel B only. Mode 2 counts edges of channel A only. Both of these give two counts per signal period. Mode 3 counts edges of both channels, which gives four counts per period. Mode 0 holds the count. The direction rules are chosen so that forward rotation, with A leading B, counts up in every mode.

The count runs between zero and a programmable reload value and wraps in both directions. Each wrap emits a single-cycle update pulse, which a neighbouring block can use to extend the position or to start a sampling event.

Top module: `qenc_counter`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `count_o` is 0, `dir_down_o` is 0 and `wrap_o` is 0.
- R2: With `mode_i` = 2'b01, only transitions of `ch_b_i` are counted. A B edge counts up when A equals B after the edge and down otherwise. Transitions of `ch_a_i` leave `count_o` and `dir_down_o` unchanged.
- R3: With `mode_i` = 2'b10, only transitions of `ch_a_i` are counted. An A edge counts down when A equals B after the edge and up otherwise. Transitions of `ch_b_i` leave `count_o` and `dir_down_o` unchanged.
- R4: With `mode_i` = 2'b11, transitions of both channels are counted with the rules of R2 and R3. The forward sequence (A,B) = 00,10,11,01,00 adds 4, and the reverse sequence subtracts 4.
- R5: With `mode_i` = 2'b00, no transition changes `count_o`, `dir_down_o` or `wrap_o`.
- R6: Counting up from a value at or above `reload_i` gives 0 and raises `wrap_o` for exactly one cycle.
- R7: Counting down from 0 gives `reload_i` and raises `wrap_o` for exactly one cycle.
- R8: When both channels change in the same synchronized sample, which is an illegal transition, the count, the direction flag and `wrap_o` are left unchanged.
- R9: `dir_down_o` is 1 after a counted down step and 0 after a counted up step. It keeps its value while nothing is counted.
- R10: An input change presented before a rising clock edge shows on `count_o` after that edge and two more, and not after only two edges.
- R11: Changing `mode_i` does not alter `count_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Resolution select: 0 hold, 1 B edges, 2 A edges, 3 both |
| ch_a_i | input | 1 | Encoder channel A, asynchronous |
| ch_b_i | input | 1 | Encoder channel B, asynchronous |
| reload_i | input | CNT_W | Upper limit of the count (wrap value) |
| count_o | output | CNT_W | Current position count |
| dir_down_o | output | 1 | 1 when the last counted step was downward |
| wrap_o | output | 1 | One-cycle pulse on an up or down wrap |

## Verification
Full forward and reverse Gray sequences are applied in every mode. Mode 3 is separated from the two half-resolution modes by the count reached after one period, and modes 1 and 2 are separated from each other by which channel's transitions are ignored. Reverse sequences confirm that the sign rule is mirrored between the channels. A simultaneous change of both channels starting from zero is used to separate "ignored" from "counted down with a wrap". Runs with a small reload value reach the wrap in both directions and check the length of the pulse.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;

    typedef enum logic [1:0] {
        QM_HOLD    = 2'd0,
        QM_EDGE_B  = 2'd1,
        QM_EDGE_A  = 2'd2,
        QM_EDGE_AB = 2'd3
    } qmode_e;

    typedef struct packed {
        logic a;
        logic b;
    } qpair_t;

    typedef struct packed {
        logic valid;
        logic down;
    } qstep_t;

    // Direction after an A transition: down when levels agree.
    function automatic logic a_edge_down(qpair_t now);
        return (now.a == now.b);
    endfunction

    // Direction after a B transition: mirrored rule.
    function automatic logic b_edge_down(qpair_t now);
        return (now.a != now.b);
    endfunction

endpackage

// File: rtl/qenc_sync.sv
`timescale 1ns/1ps
module qenc_sync
    import qenc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  qpair_t raw_i,
    output qpair_t sync_o
);

    qpair_t stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg_q[g] <= '0;
                else     stg_q[g] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg_q[g] <= '0;
                else     stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/qenc_decode.sv
`timescale 1ns/1ps
module qenc_decode
    import qenc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  qpair_t cur_i,
    input  qmode_e mode_i,
    output qstep_t step_o
);

    qpair_t prev_q;
    logic   a_edge;
    logic   b_edge;
    logic   use_a;
    logic   use_b;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur_i;
    end

    assign a_edge = cur_i.a ^ prev_q.a;
    assign b_edge = cur_i.b ^ prev_q.b;
    assign use_a  = (mode_i == QM_EDGE_A) || (mode_i == QM_EDGE_AB);
    assign use_b  = (mode_i == QM_EDGE_B) || (mode_i == QM_EDGE_AB);

    always_comb begin
        step_o = '0;
        if (a_edge && b_edge) begin
            step_o = '0;
        end else if (a_edge && use_a) begin
            step_o.valid = 1'b1;
            step_o.down  = a_edge_down(cur_i);
        end else if (b_edge && use_b) begin
            step_o.valid = 1'b1;
            step_o.down  = b_edge_down(cur_i);
        end
    end

    // R8
    illegal_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (a_edge && b_edge) |-> !step_o.valid);

    // R5
    hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == QM_HOLD) |-> !step_o.valid);

endmodule

// File: rtl/qenc_count.sv
`timescale 1ns/1ps
module qenc_count
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  qstep_t           step_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             dir_q, dir_n;
    logic             wrap_q, wrap_n;

    always_comb begin
        cnt_n  = cnt_q;
        dir_n  = dir_q;
        wrap_n = 1'b0;
        if (step_i.valid) begin
            dir_n = step_i.down;
            if (step_i.down) begin
                if (cnt_q == ZERO) begin
                    cnt_n  = reload_i;
                    wrap_n = 1'b1;
                end else begin
                    cnt_n = cnt_q - ONE;
                end
            end else begin
                if (cnt_q >= reload_i) begin
                    cnt_n  = ZERO;
                    wrap_n = 1'b1;
                end else begin
                    cnt_n = cnt_q + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= ZERO;
            dir_q  <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            dir_q  <= dir_n;
            wrap_q <= wrap_n;
        end
    end

    assign cnt_o  = cnt_q;
    assign down_o = dir_q;
    assign wrap_o = wrap_q;

    // R2 R3 R4: a plain up step adds one
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i.valid && !step_i.down && cnt_q < reload_i)
            |=> cnt_q == $past(cnt_q) + ONE);

    // R2 R3 R4: a plain down step subtracts one
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i.valid && step_i.down && cnt_q != ZERO)
            |=> cnt_q == $past(cnt_q) - ONE);

    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_i.valid |=> $stable(dir_q) && !wrap_q);

    // R6
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && !dir_q) |-> cnt_q == ZERO);

endmodule

// File: rtl/qenc_counter.sv
`timescale 1ns/1ps
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic             ch_a_i,
    input  logic             ch_b_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_down_o,
    output logic             wrap_o
);

    qpair_t raw;
    qpair_t synced;
    qstep_t step;
    qmode_e mode;

    assign raw.a = ch_a_i;
    assign raw.b = ch_b_i;
    assign mode  = qmode_e'(mode_i);

    qenc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw),
        .sync_o (synced)
    );

    qenc_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (synced),
        .mode_i (mode),
        .step_o (step)
    );

    qenc_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .reload_i (reload_i),
        .cnt_o    (count_o),
        .down_o   (dir_down_o),
        .wrap_o   (wrap_o)
    );

    // R5
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd0) |=> $stable(count_o));

    // R7
    wrap_after_step_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> $past(step.valid));

endmodule

// File: tb/qenc_counter_tb.sv
`timescale 1ns/1ps
module qenc_counter_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'd0;
    logic         a = 1'b0;
    logic         b = 1'b0;
    logic [W-1:0] reload = 16'd5;
    logic [W-1:0] count;
    logic         dir_down;
    logic         wrap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] last_cnt = '0;

    always #2.5 clk = ~clk;

    qenc_counter #(.CNT_W(W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .ch_a_i     (a),
        .ch_b_i     (b),
        .reload_i   (reload),
        .count_o    (count),
        .dir_down_o (dir_down),
        .wrap_o     (wrap)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one input sample and check outputs at the expected cycle.
    task automatic step(input logic na, input logic nb, input int ec,
                        input logic ed, input logic ew, input string req);
        @(negedge clk);
        a = na;
        b = nb;
        repeat (2) @(posedge clk);
        #1;
        check("R10", "count before third edge", int'(count), int'(last_cnt));
        @(posedge clk);
        #1;
        check(req, "count", int'(count), ec);
        check(req, "dir_down", int'(dir_down), int'(ed));
        check(req, "wrap", int'(wrap), int'(ew));
        @(posedge clk);
        #1;
        check(req, "wrap one cycle", int'(wrap), 0);
        last_cnt = W'(ec);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "count in reset", int'(count), 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "count", int'(count), 0);
        check("R1", "dir_down", int'(dir_down), 0);
        check("R1", "wrap", int'(wrap), 0);
    endtask

    task automatic t_hold();
        mode = 2'd0;
        step(1, 0, 0, 0, 0, "R5");
        step(1, 1, 0, 0, 0, "R5");
        step(0, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, "R5");
    endtask

    task automatic t_x4();
        mode = 2'd3;
        step(1, 0, 1, 0, 0, "R4");
        step(1, 1, 2, 0, 0, "R4");
        step(0, 1, 3, 0, 0, "R4");
        step(0, 0, 4, 0, 0, "R4");
        step(0, 1, 3, 1, 0, "R9");
        step(1, 1, 2, 1, 0, "R4");
        step(1, 0, 1, 1, 0, "R4");
        step(0, 0, 0, 1, 0, "R4");
    endtask

    task automatic t_wraps();
        mode = 2'd3;
        step(0, 1, 5, 1, 1, "R7");
        step(0, 0, 0, 0, 1, "R6");
    endtask

    task automatic t_edge_b();
        mode = 2'd1;
        step(1, 0, 0, 0, 0, "R2");
        step(1, 1, 1, 0, 0, "R2");
        step(0, 1, 1, 0, 0, "R2");
        step(0, 0, 2, 0, 0, "R2");
        step(0, 1, 1, 1, 0, "R2");
        step(1, 1, 1, 1, 0, "R2");
        step(1, 0, 0, 1, 0, "R2");
        step(0, 0, 0, 1, 0, "R2");
    endtask

    task automatic t_edge_a();
        mode = 2'd2;
        step(1, 0, 1, 0, 0, "R3");
        step(1, 1, 1, 0, 0, "R3");
        step(0, 1, 2, 0, 0, "R3");
        step(0, 0, 2, 0, 0, "R3");
        step(0, 1, 2, 0, 0, "R3");
        step(1, 1, 1, 1, 0, "R3");
        step(1, 0, 1, 1, 0, "R3");
        step(0, 0, 0, 1, 0, "R3");
    endtask

    task automatic t_illegal();
        mode = 2'd3;
        step(1, 1, 0, 1, 0, "R8");
        step(0, 0, 0, 1, 0, "R8");
    endtask

    task automatic t_small_reload();
        mode = 2'd3;
        reload = 16'd3;
        step(1, 0, 1, 0, 0, "R6");
        step(1, 1, 2, 0, 0, "R6");
        step(0, 1, 3, 0, 0, "R6");
        step(0, 0, 0, 0, 1, "R6");
    endtask

    task automatic t_mode_change();
        mode = 2'd3;
        step(1, 0, 1, 0, 0, "R11");
        @(negedge clk);
        mode = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R11", "count after mode 0", int'(count), 1);
        @(negedge clk);
        mode = 2'd1;
        repeat (3) @(posedge clk);
        #1;
        check("R11", "count after mode 1", int'(count), 1);
        check("R11", "dir_down after mode 1", int'(dir_down), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_hold();
        t_x4();
        t_wraps();
        t_edge_b();
        t_edge_a();
        t_illegal();
        t_small_reload();
        t_mode_change();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule